// File: doc/BRIEF.md
# Programmable Period Timer with Postscaled Flag

This block is an up-counter that advances on an internal timebase tick, passed first through a prescaler that divides by 1, 4 or 16. The count is compared with a programmable period value. When the two are equal, the next counter step returns the count to zero instead of incrementing it, so one full period spans the period value plus one steps. Each such restart produces a one-cycle pulse on an output that neighbouring logic can use as a timebase, for example to pace a serial shifter.

A postscaler counts restarts and sets a sticky interrupt flag once every N restarts, where N is any whole number from 1 to 16. Software reaches the count, the period and the control fields through a simple write port and a registered read port. It clears the flag with a dedicated input. With the prescaler at 16, the period at 255 and the postscaler at 16, the flag fires once every 65536 ticks, which is about 15.26 Hz from a 1 MHz tick.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0, the period reads 255, the control reads 0, and both `irq_flag` and `period_tick` are low.
- R2: The control field at bits 2:1 selects the prescale ratio: 0 gives 1, 1 gives 4, and 2 or 3 give 16. The count advances once for every that many cycles in which `tick_in` is high while the timer is enabled.
- R3: A counter step taken when the count equals the period loads zero. Every other step adds one. Between restarts there are period+1 steps.
- R4: Each restart raises `period_tick` for exactly the one cycle after the clock edge that restarted the count. While that pulse is high, the count is zero.
- R5: The control field at bits 6:3 holds M. `irq_flag` becomes set on every (M+1)-th restart.
- R6: `irq_flag` stays set until a cycle in which `flag_clr` is high. If the flag is being set in that same cycle, the set wins.
- R7: Control bit 0 is the enable. While it is low, the count, the prescaler and the postscaler hold their values.
- R8: A write to the count (select 0) or to the control (select 2) clears the prescaler and the postscaler. No counter step happens in the cycle of that write.
- R9: Writes with `wr_en` high store `wr_data` into the register chosen by `wr_sel`: 0 is count, 1 is period, 2 is control. `rd_data` shows the register chosen by `rd_sel` one cycle later, as it stood before that edge. Select 3 and unused control bits read as 0.
- R10: The period may be rewritten while the timer runs. A count above the period keeps climbing, wraps from 255 to 0 without a restart pulse, and then restarts normally at the period.
- R11: With prescale 16, period 255 and postscale field 15, the flag sets exactly 65536 ticks after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Internal timebase tick, one cycle per event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 period, 2 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | 8 | Registered read data |
| flag_clr | input | 1 | Clears the interrupt flag |
| period_tick | output | 1 | One-cycle pulse per counter restart |
| irq_flag | output | 1 | Sticky postscaled interrupt flag |

## Verification
A bad prescaler or count state shows up in the count readback within one read cycle, and as a shifted `period_tick` within one period. A bad postscaler state stays hidden until the flag sets one restart too early or too late, so it is only seen up to N periods later. That is why the bench compares the flag every cycle against an independent model, and measures the full 65536-tick interval for the slowest setting.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int EN_BIT  = 0;
  localparam int PRE_LO  = 1;
  localparam int POST_LO = 3;

  function automatic int unsigned pre_div(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             clr,
  input  logic [1:0]       sel,
  output logic             step,
  output logic [PRE_W-1:0] pre_q
);
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'(ptmr_pkg::pre_div(sel) - 1);
    step  = en && tick && !clr && (pre_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      pre_q <= '0;
    else if (en && tick)
      pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             cnt_we,
  input  logic             per_we,
  input  logic [CNT_W-1:0] wd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_q,
  output logic             restart,
  output logic             ptick_q
);
  always_comb restart = step && (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      per_q   <= '1;
      ptick_q <= 1'b0;
    end else begin
      ptick_q <= restart;
      if (cnt_we)
        cnt_q <= wd;
      else if (restart)
        cnt_q <= '0;
      else if (step)
        cnt_q <= cnt_q + 1'b1;
      if (per_we)
        per_q <= wd;
    end
  end
endmodule

// File: rtl/ptmr_post.sv
module ptmr_post #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              restart,
  input  logic [POST_W-1:0] n_sel,
  input  logic              flag_clr,
  output logic [POST_W-1:0] post_q,
  output logic              wrap,
  output logic              flag_q
);
  always_comb wrap = restart && (post_q == n_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (clr)
        post_q <= '0;
      else if (restart)
        post_q <= wrap ? '0 : post_q + 1'b1;
      if (wrap)
        flag_q <= 1'b1;
      else if (flag_clr)
        flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic             flag_clr,
  output logic             period_tick,
  output logic             irq_flag
);
  import ptmr_pkg::*;

  localparam int CTRL_W = POST_LO + POST_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              en_w;
  logic [1:0]        pre_sel;
  logic [POST_W-1:0] post_n;
  logic              cnt_we, per_we, ctl_we, clr_w;
  logic              step;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q, per_q;
  logic              restart;
  logic [POST_W-1:0] post_q;
  logic              wrap;

  always_comb begin
    en_w    = ctrl_q[EN_BIT];
    pre_sel = ctrl_q[PRE_LO +: 2];
    post_n  = ctrl_q[POST_LO +: POST_W];
    cnt_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
    per_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_PERIOD);
    ctl_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    clr_w   = cnt_we || ctl_we;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (ctl_we)
      ctrl_q <= wr_data[CTRL_W-1:0];
  end

  ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(en_w), .tick(tick_in), .clr(clr_w),
    .sel(pre_sel), .step(step), .pre_q(pre_q)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .step(step), .cnt_we(cnt_we), .per_we(per_we),
    .wd(wr_data), .cnt_q(cnt_q), .per_q(per_q), .restart(restart),
    .ptick_q(period_tick)
  );

  ptmr_post #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst(rst), .clr(clr_w), .restart(restart), .n_sel(post_n),
    .flag_clr(flag_clr), .post_q(post_q), .wrap(wrap), .flag_q(irq_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_sel))
        SEL_COUNT:  rd_data <= cnt_q;
        SEL_PERIOD: rd_data <= per_q;
        SEL_CTRL:   rd_data <= CNT_W'(ctrl_q);
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              flag_clr,
  input logic              en_w,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic [POST_W-1:0] post_q,
  input logic [POST_W-1:0] post_n,
  input logic              wrap,
  input logic              period_tick,
  input logic              irq_flag
);
  assert_tick_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    period_tick |-> (cnt_q == '0));

  assert_post_range_R5: assert property (@(posedge clk) disable iff (rst)
    post_q <= post_n);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> irq_flag);

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_w && !wr_en) |=> ($stable(cnt_q) && $stable(pre_q) && $stable(post_q)));

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel == 2'd0 || wr_sel == 2'd2)) |=> (pre_q == '0 && post_q == '0));
endmodule

bind period_timer period_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .POST_W(POST_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .flag_clr(flag_clr),
  .en_w(en_w), .cnt_q(cnt_q), .pre_q(pre_q), .post_q(post_q), .post_n(post_n),
  .wrap(wrap), .period_tick(period_tick), .irq_flag(irq_flag)
);

// File: tb/period_timer_bench.sv
module period_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       flag_clr = 1'b0;
  logic       period_tick;
  logic       irq_flag;

  int tests = 0;
  int fails = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  period_timer u_period_timer (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .flag_clr(flag_clr),
    .period_tick(period_tick), .irq_flag(irq_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference state, built from the requirement text
  int m_cnt, m_per, m_ctrl, m_pre, m_post, m_rd;
  bit m_flag, m_tick;

  function automatic int div_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 16;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per = 255; m_ctrl = 0; m_pre = 0; m_post = 0;
      m_rd = 0; m_flag = 0; m_tick = 0;
    end else begin
      automatic bit en = m_ctrl[0];
      automatic int dv = div_of((m_ctrl >> 1) & 3);
      automatic int nn = ((m_ctrl >> 3) & 15) + 1;
      automatic bit wc = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd2);
      automatic bit adv = en && tick_in && !wc && (m_pre + 1 == dv);
      automatic bit rs = adv && (m_cnt == m_per);
      automatic bit fs = rs && (m_post + 1 == nn);
      case (rd_sel)
        2'd0: m_rd = m_cnt;
        2'd1: m_rd = m_per;
        2'd2: m_rd = m_ctrl;
        default: m_rd = 0;
      endcase
      m_tick = rs;
      if (wc) m_pre = 0;
      else if (en && tick_in) m_pre = (m_pre + 1 == dv) ? 0 : m_pre + 1;
      if (wc) m_post = 0;
      else if (rs) m_post = fs ? 0 : m_post + 1;
      if (fs) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (wr_en && wr_sel == 2'd0) m_cnt = wr_data;
      else if (rs) m_cnt = 0;
      else if (adv) m_cnt = (m_cnt + 1) % 256;
      if (wr_en && wr_sel == 2'd1) m_per = wr_data;
      if (wr_en && wr_sel == 2'd2) m_ctrl = wr_data & 8'h7F;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst && !done) begin
      chk("R9 rd_data", rd_data, m_rd);
      chk("R4 period_tick", period_tick, m_tick);
      chk("R6 irq_flag", irq_flag, m_flag);
    end
  end

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sel, output int val);
    tick_in = 1'b0; rd_sel = sel[1:0];
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic run(input int n);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    int v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    // R1 reset state
    rd(0, v); chk("R1 count", v, 0);
    rd(1, v); chk("R1 period", v, 255);
    rd(2, v); chk("R1 control", v, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 tick", period_tick, 0);

    // R2 prescale by 4, then by 16
    wr(2, 8'h03); run(40); rd(0, v); chk("R2 div4", v, 10);
    wr(0, 0); wr(2, 8'h05); run(64); rd(0, v); chk("R2 div16", v, 4);
    wr(0, 0); wr(2, 8'h07); run(32); rd(0, v); chk("R2 code3", v, 2);

    // R3 / R5 restart at period 5, postscale 1
    wr(1, 5); wr(0, 0); wr(2, 8'h01); clear_flag();
    run(5); rd(0, v); chk("R3 at period", v, 5); chk("R5 before", irq_flag, 0);
    run(1); rd(0, v); chk("R3 restart", v, 0); chk("R5 flag set", irq_flag, 1);
    run(3); rd(0, v); chk("R3 after", v, 3);

    // R5 postscale 3: flag after 3 periods of 6
    wr(0, 0); wr(2, 8'h11); clear_flag();
    run(17); chk("R5 n3 early", irq_flag, 0);
    run(1); chk("R5 n3 set", irq_flag, 1);

    // R10 period below count: wrap to 0 without restart
    wr(1, 3); wr(0, 10); wr(2, 8'h01); clear_flag();
    run(246); rd(0, v); chk("R10 wrapped", v, 0); chk("R10 no flag", irq_flag, 0);
    run(3); rd(0, v); chk("R10 climb", v, 3);
    run(1); rd(0, v); chk("R10 restart", v, 0); chk("R10 flag", irq_flag, 1);

    // R6 set wins over clear: period 0 restarts every tick
    wr(1, 0); wr(0, 0); wr(2, 8'h01);
    flag_clr = 1'b1; run(5); flag_clr = 1'b0;
    chk("R6 set wins", irq_flag, 1);
    clear_flag(); chk("R6 cleared", irq_flag, 0);
    run(2); clear_flag(); chk("R6 clear again", irq_flag, 0);

    // R7 disabled hold
    wr(1, 200); wr(0, 17); wr(2, 8'h00); run(50); rd(0, v); chk("R7 hold", v, 17);
    rd(2, v); chk("R9 ctrl read", v, 0);

    // R8 count write clears prescaler phase
    wr(2, 8'h03); run(3); wr(0, 40); run(3); rd(0, v); chk("R8 pre cleared", v, 40);
    run(1); rd(0, v); chk("R8 step", v, 41);
    rd(3, v); chk("R9 sel3", v, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int s;
      tick_in  = ($urandom % 4) != 0;
      flag_clr = ($urandom % 8) == 0;
      rd_sel   = 2'($urandom % 4);
      wr_en    = ($urandom % 12) == 0;
      s        = $urandom % 4;
      wr_sel   = 2'(s);
      if (s == 2) wr_data = 8'(((($urandom % 8) != 0) ? 1 : 0) | (($urandom % 4) << 1) | (($urandom % 4) << 3));
      else        wr_data = 8'($urandom % 8);
      @(negedge clk);
    end
    wr_en = 1'b0; flag_clr = 1'b0; tick_in = 1'b0;

    // R11 slowest flag rate
    wr(1, 255); wr(0, 0); clear_flag(); wr(2, 8'h7D);
    tick_in = 1'b1; n = 0;
    while (!irq_flag && n < 70000) begin @(negedge clk); n++; end
    tick_in = 1'b0;
    chk("R11 interval", n, 65536);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule